// File: doc/BRIEF.md
# Parity Stripe Small-Write Sequencer

This controller manages an array of `NDATA` data disks and one extra disk slot per stripe that holds parity. Host block numbers are spread over the data disks one after another, so consecutive blocks land on consecutive disks. A new stripe begins once every data disk has been used. Parity sits either on one fixed disk or on a disk that moves from stripe to stripe. The placement is chosen per request with `rot_mode`.

A host write updates one data block and its parity with four serial disk accesses. A host read touches only the disk that holds the block. If a disk is marked failed and the read targets it, the controller rebuilds the word by XOR of every other disk in the stripe. Each disk port has a valid/ready request on a shared command bus and a per-disk read-response strobe. Every block is one `WW`-bit word.

Top module: `raid_parity_ctrl`

## Requirements
- R1: With `rot_mode`=0, block b lives at stripe address b/NDATA on disk b mod NDATA, and the parity of every stripe is on disk NDATA.
- R2: With `rot_mode`=1, the parity of stripe s is on disk NDATA−(s mod (NDATA+1)), and the data blocks of the stripe take the remaining disks in ascending order.
- R3: A write issues exactly four accesses in this order: read of the data disk, read of the parity disk, write of the data disk, write of the parity disk. Neither write starts before both read responses have arrived, and at most one `dk_req` bit is high at any time.
- R4: The data write carries the host word. The parity write carries old parity XOR old data XOR host word.
- R5: A read of a block on a healthy disk makes a single access to that disk. `host_rdata` returns the word with `done`.
- R6: When `fail_en`=1 and the block is on disk `fail_disk`, every other disk is read at the stripe address in ascending disk order. `host_rdata` is the XOR of those words.
- R7: A write whose data or parity disk equals `fail_disk` while `fail_en`=1 makes no disk access. It raises `done` and `err` in the cycle after acceptance.
- R8: `busy` is high from the cycle after acceptance until `done`. `done` is a one-cycle pulse with `busy` low. `host_req` is ignored while `busy` is high, and no `dk_req` is raised while `busy` is low.
- R9: While a `dk_req` bit is high without `dk_rdy`, that bit and `dk_we`, `dk_addr` and `dk_wdata` hold their values.
- R10: After reset `busy`, `done` and `dk_req` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rot_mode | input | 1 | 1 selects moving parity, 0 selects fixed parity; sampled at acceptance |
| fail_en | input | 1 | A disk is marked failed |
| fail_disk | input | $clog2(NDATA+1) | Index of the failed disk |
| host_req | input | 1 | Host request, taken when idle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_blk | input | BW | Logical block number |
| host_wdata | input | WW | Word to write |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Completion was a refused write |
| host_rdata | output | WW | Read result, valid with done |
| dk_req | output | NDATA+1 | Per-disk request valid |
| dk_rdy | input | NDATA+1 | Per-disk request ready |
| dk_we | output | 1 | Shared write enable |
| dk_addr | output | BW | Shared stripe address |
| dk_wdata | output | WW | Shared write word |
| dk_rvld | input | NDATA+1 | Per-disk read response strobe |
| dk_rdata | input | (NDATA+1)*WW | Per-disk read words, disk k at bits k*WW upward |

## Verification
Two events can fall in the same clock edge. One is the final response or acknowledge that ends a job. The other is a still-asserted host request that must not start a second job. The bench holds `host_req` high, together with its block and data, for the whole job and releases it only after seeing `done`, so the request is present at the very edge where the controller returns to idle. Any phantom restart shows up as an unexpected disk handshake or as a `dk_req` with `busy` low, and the per-clock comparison against the bench's expected access queue flags both.

// File: rtl/raid_parity_ctrl.sv
module raid_parity_ctrl #(
  parameter int NDATA = 4,
  parameter int WW    = 16,
  parameter int BW    = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rot_mode,
  input  logic                     fail_en,
  input  logic [$clog2(NDATA+1)-1:0] fail_disk,
  input  logic                     host_req,
  input  logic                     host_we,
  input  logic [BW-1:0]            host_blk,
  input  logic [WW-1:0]            host_wdata,
  output logic                     busy,
  output logic                     done,
  output logic                     err,
  output logic [WW-1:0]            host_rdata,
  output logic [NDATA:0]           dk_req,
  input  logic [NDATA:0]           dk_rdy,
  output logic                     dk_we,
  output logic [BW-1:0]            dk_addr,
  output logic [WW-1:0]            dk_wdata,
  input  logic [NDATA:0]           dk_rvld,
  input  logic [(NDATA+1)*WW-1:0]  dk_rdata
);
  localparam int ND = NDATA + 1;
  localparam int DW = $clog2(ND);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} st_t;
  typedef enum logic [1:0] {K_RD, K_WR, K_RB} kind_t;

  st_t           st;
  kind_t         kind;
  logic [1:0]    step;
  logic [DW-1:0] cd, dd, pd, fd;
  logic [BW-1:0] addr;
  logic [WW-1:0] nd, acc, wd_q, rdata_q;
  logic          we_q, done_q, err_q;

  logic [DW-1:0] m_dd, m_pd, rb_nx;
  logic [BW-1:0] m_stripe;
  logic          rb_last;
  logic [WW-1:0] rsel;

  // parity walks downward from the last disk as the stripe number grows
  always_comb begin
    int s, i, p;
    s = int'(host_blk) / NDATA;
    i = int'(host_blk) % NDATA;
    p = rot_mode ? NDATA - (s % ND) : NDATA;
    m_stripe = BW'(s);
    m_pd     = DW'(p);
    m_dd     = DW'((i < p) ? i : i + 1);
  end

  always_comb begin
    int n;
    n = int'(cd) + 1;
    if (n == int'(fd)) n = n + 1;
    rb_last = (n > NDATA);
    rb_nx   = DW'(n);
  end

  assign rsel       = dk_rdata[cd*WW +: WW];
  assign busy       = (st != S_IDLE);
  assign done       = done_q;
  assign err        = err_q;
  assign host_rdata = rdata_q;
  assign dk_req     = (st == S_REQ) ? (ND'(1) << cd) : '0;
  assign dk_we      = we_q;
  assign dk_addr    = addr;
  assign dk_wdata   = wd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; kind <= K_RD; step <= '0;
      cd <= '0; dd <= '0; pd <= '0; fd <= '0; addr <= '0;
      nd <= '0; acc <= '0; wd_q <= '0; rdata_q <= '0;
      we_q <= 1'b0; done_q <= 1'b0; err_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (host_req) begin
          if (host_we && fail_en && (fail_disk == m_dd || fail_disk == m_pd)) begin
            done_q <= 1'b1;
            err_q  <= 1'b1;
          end else begin
            err_q <= 1'b0;
            st    <= S_REQ;
            step  <= '0;
            acc   <= '0;
            we_q  <= 1'b0;
            addr  <= m_stripe;
            dd    <= m_dd;
            pd    <= m_pd;
            nd    <= host_wdata;
            fd    <= fail_disk;
            cd    <= m_dd;
            if (host_we) kind <= K_WR;
            else if (fail_en && fail_disk == m_dd) begin
              kind <= K_RB;
              cd   <= (fail_disk == '0) ? DW'(1) : '0;
            end else kind <= K_RD;
          end
        end
        S_REQ: if (dk_rdy[cd]) begin
          if (!we_q) st <= S_WAIT;
          else if (step == 2'd2) begin
            step <= 2'd3;
            cd   <= pd;
            wd_q <= acc ^ nd;
          end else begin
            st     <= S_IDLE;
            done_q <= 1'b1;
            we_q   <= 1'b0;
          end
        end
        S_WAIT: if (dk_rvld[cd]) begin
          st <= S_REQ;
          case (kind)
            K_RD: begin
              st      <= S_IDLE;
              done_q  <= 1'b1;
              rdata_q <= rsel;
            end
            K_RB: if (rb_last) begin
              st      <= S_IDLE;
              done_q  <= 1'b1;
              rdata_q <= acc ^ rsel;
            end else begin
              acc <= acc ^ rsel;
              cd  <= rb_nx;
            end
            default: if (step == 2'd0) begin
              acc  <= rsel;
              step <= 2'd1;
              cd   <= pd;
            end else begin
              acc  <= acc ^ rsel;
              step <= 2'd2;
              cd   <= dd;
              we_q <= 1'b1;
              wd_q <= nd;
            end
          endcase
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/raid_parity_chk.sv
module raid_parity_chk #(
  parameter int ND = 5,
  parameter int WW = 16,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [ND-1:0] dk_req,
  input logic [ND-1:0] dk_rdy,
  input logic          dk_we,
  input logic [AW-1:0] dk_addr,
  input logic [WW-1:0] dk_wdata,
  input logic          busy,
  input logic          done,
  input logic          err
);
  p_single_access_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dk_req));

  p_hold_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|(dk_req & ~dk_rdy)) |=> (dk_req == $past(dk_req)) && $stable(dk_we)
                              && $stable(dk_addr) && $stable(dk_wdata));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_quiet_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (dk_req == '0));

  p_err_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> done);
endmodule

bind raid_parity_ctrl raid_parity_chk #(.ND(NDATA+1), .WW(WW), .AW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .dk_req(dk_req), .dk_rdy(dk_rdy), .dk_we(dk_we),
  .dk_addr(dk_addr), .dk_wdata(dk_wdata), .busy(busy), .done(done), .err(err)
);

// File: tb/sim_raid_parity_ctrl.sv
module sim_raid_parity_ctrl;
  localparam int CLK_NS = 10;
  localparam int N  = 4;
  localparam int ND = 5;
  localparam int WW = 16;
  localparam int BW = 8;
  localparam int NS = 64;
  localparam int WD = 150000;

  typedef struct {
    int          d;
    bit          we;
    int          a;
    logic [15:0] wd;
    string       tag;
  } acc_t;

  logic clk = 0, rst_n = 0;
  logic rot_mode = 0, fail_en = 0;
  logic [2:0] fail_disk = 0;
  logic host_req = 0, host_we = 0;
  logic [BW-1:0] host_blk = 0;
  logic [WW-1:0] host_wdata = 0;
  logic busy, done, err, dk_we;
  logic [WW-1:0] host_rdata, dk_wdata;
  logic [ND-1:0] dk_req;
  logic [ND-1:0] dk_rdy = 0, dk_rvld = 0;
  logic [BW-1:0] dk_addr;
  logic [ND*WW-1:0] dk_rdata = 0;

  logic [15:0] mem [ND][NS];
  acc_t q[$];
  int nchk = 0, nfail = 0, cyc = 0;
  int pend = 0, pdisk = 0, paddr = 0;
  logic [ND-1:0] prev_req = 0, prev_rdy = 0;
  bit op_over = 0, exp_err = 0, exp_rd = 0;
  logic [15:0] exp_val = 0;
  string rdtag = "R5";

  always #(CLK_NS/2) clk = ~clk;

  raid_parity_ctrl #(.NDATA(N), .WW(WW), .BW(BW)) u0 (
    .clk(clk), .rst_n(rst_n), .rot_mode(rot_mode), .fail_en(fail_en),
    .fail_disk(fail_disk), .host_req(host_req), .host_we(host_we),
    .host_blk(host_blk), .host_wdata(host_wdata), .busy(busy), .done(done),
    .err(err), .host_rdata(host_rdata), .dk_req(dk_req), .dk_rdy(dk_rdy),
    .dk_we(dk_we), .dk_addr(dk_addr), .dk_wdata(dk_wdata), .dk_rvld(dk_rvld),
    .dk_rdata(dk_rdata)
  );

  task automatic chk(bit ok, string tag, longint act, longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  endtask

  // disk models and per-clock comparison, all at the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      logic [ND-1:0] hs;
      cyc++;
      if (cyc > WD) begin
        nfail++;
        $display("FAIL R3 watchdog actual=%0d expected<%0d", cyc, WD);
        finish_run();
      end
      if (prev_req != 0 && (prev_req & prev_rdy) == 0)
        chk(dk_req == prev_req, "R9 hold", dk_req, prev_req);
      chk(busy || dk_req == 0, "R8 idle access", dk_req, 0);
      chk($onehot0(dk_req), "R3 one access", dk_req, 0);

      dk_rvld = '0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          dk_rvld[pdisk] = 1'b1;
          dk_rdata[pdisk*WW +: WW] = mem[pdisk][paddr];
        end
      end
      dk_rdy   = ND'($urandom | $urandom);
      prev_req = dk_req;
      prev_rdy = dk_rdy;
      hs = dk_req & dk_rdy;
      if (hs != 0) begin
        int d;
        d = 0;
        for (int k = 0; k < ND; k++) if (hs[k]) d = k;
        if (q.size() == 0) chk(0, "R5 extra access", hs, 0);
        else begin
          acc_t e;
          e = q.pop_front();
          chk(d == e.d && dk_we == e.we && int'(dk_addr) == e.a, e.tag,
              d*4096 + int'(dk_we)*256 + int'(dk_addr),
              e.d*4096 + int'(e.we)*256 + e.a);
          if (dk_we) begin
            if (e.we) chk(dk_wdata == e.wd, e.tag, dk_wdata, e.wd);
            mem[d][dk_addr] = dk_wdata;
          end else begin
            pend  = 1 + ($urandom % 3);
            pdisk = d;
            paddr = int'(dk_addr);
          end
        end
      end
      if (done) begin
        chk(err == exp_err, "R7 err flag", err, exp_err);
        chk(!busy, "R8 done with busy low", busy, 0);
        if (!exp_err && exp_rd) chk(host_rdata == exp_val, rdtag, host_rdata, exp_val);
        chk(q.size() == 0, "R3 missing access", q.size(), 0);
        op_over = 1;
      end
    end
  end

  task automatic op(bit we, int blk, logic [15:0] wd);
    int s, i, p, dd;
    string mt;
    s = blk / N;
    i = blk % N;
    p = rot_mode ? N - (s % ND) : N;
    dd = (i < p) ? i : i + 1;
    mt = rot_mode ? "R2" : "R1";
    q.delete();
    exp_err = 0;
    exp_rd  = 0;
    if (we && fail_en && (int'(fail_disk) == dd || int'(fail_disk) == p)) exp_err = 1;
    else if (we) begin
      q.push_back('{dd, 1'b0, s, 16'h0, mt});
      q.push_back('{p, 1'b0, s, 16'h0, "R3"});
      q.push_back('{dd, 1'b1, s, wd, "R4"});
      q.push_back('{p, 1'b1, s, mem[p][s] ^ mem[dd][s] ^ wd, "R4"});
    end else if (fail_en && int'(fail_disk) == dd) begin
      for (int k = 0; k < ND; k++)
        if (k != int'(fail_disk)) q.push_back('{k, 1'b0, s, 16'h0, "R6"});
      exp_rd = 1; exp_val = mem[dd][s]; rdtag = "R6";
    end else begin
      q.push_back('{dd, 1'b0, s, 16'h0, mt});
      exp_rd = 1; exp_val = mem[dd][s]; rdtag = "R5";
    end
    @(negedge clk);
    op_over    = 0;
    host_req   = 1;
    host_we    = we;
    host_blk   = BW'(blk);
    host_wdata = wd;
    wait (op_over);
    host_req = 0;
  endtask

  task automatic cfg(bit r, bit fe, int f);
    rot_mode  = r;
    fail_en   = fe;
    fail_disk = 3'(f);
  endtask

  initial begin
    for (int a = 0; a < NS; a++) begin
      logic [15:0] x;
      x = 0;
      for (int d = 0; d < N; d++) begin
        mem[d][a] = 16'($urandom);
        x = x ^ mem[d][a];
      end
      mem[N][a] = x;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(busy == 0, "R10 busy", busy, 0);
    chk(done == 0, "R10 done", done, 0);
    chk(dk_req == 0, "R10 dk_req", dk_req, 0);

    cfg(0, 0, 0);
    for (int b = 0; b < 12; b++) op(0, b, 0);
    op(1, 5, 16'hA5A5); op(1, 0, 16'h1234); op(1, 11, 16'hFFFF);
    op(0, 5, 0); op(0, 0, 0); op(0, 11, 0);

    cfg(1, 0, 0);
    for (int b = 0; b < 28; b++) op(0, b, 0);
    op(1, 1, 16'h0F0F); op(1, 17, 16'h5555); op(1, 22, 16'h8001);
    op(0, 1, 0); op(0, 17, 0); op(0, 22, 0);

    cfg(0, 1, 2);
    op(0, 2, 0); op(0, 6, 0); op(0, 10, 0); op(0, 1, 0);
    op(1, 3, 16'h3333); op(1, 2, 16'h2222); op(1, 0, 16'h7777);
    op(0, 3, 0); op(0, 0, 0); op(0, 2, 0);

    cfg(0, 1, 4);
    op(1, 1, 16'hDEAD); op(0, 5, 0);

    cfg(1, 1, 0);
    for (int b = 0; b < 20; b++) op(0, b, 0);
    op(1, 6, 16'hBEEF); op(1, 9, 16'hC0DE);

    cfg(1, 1, 4);
    for (int b = 0; b < 20; b++) op(0, b, 0);

    for (int t = 0; t < 80; t++) begin
      cfg(1'($urandom), 1'($urandom), int'($urandom % ND));
      op(1'($urandom), int'($urandom % (NS * N)), 16'($urandom));
    end
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule